// File: doc/BRIEF.md
# Pattern Write-Readback Storage Tester

This block exercises a small synchronous storage array of data words, such as a bank of general registers or a translation table, by driving its write and read port directly. A run steps through five data patterns. For each pattern it first writes every location in ascending address order. It then reads every location back in the same order and compares each returned word with the value it wrote. Every mismatch adds to an error count. When the last comparison of the last pattern is done, a one-cycle done pulse marks the end of the run, and the final count stays on the output until the next start.

The storage returns read data one clock after the read address is presented. The tester keeps a delayed copy of the address and the expected word, so each comparison lines up with the data it belongs to.

Entries can be one word wide, or wider and made of several words that are written and read separately. The last pattern stores the entry number, so every word of an entry receives the same value.

For self-test, a fault-injection input inverts bit 0 of the word read back from one chosen address.

Top module: `pattern_store_tester`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we` and `mem_re` are low and `err_count` is zero.
- R2: A run applies five patterns in this fixed order:
  - all zeros;
  - all ones;
  - alternating bits starting with 1 at the MSB (0xAAAAAAAA for 32 bits);
  - alternating bits starting with 0 at the MSB (0x55555555);
  - the entry number of the location, zero-extended, where entry number = address >> log2(WORDS_PER_ENTRY).
- R3: Each pattern issues one write per cycle to addresses 0..NADDR-1 in ascending order, then one read per cycle over the same range, with no idle cycle in between. The next pattern's first write directly follows the previous pattern's last read, and `mem_we` and `mem_re` are never high together. `done` rises 10*NADDR+1 clock edges after the edge that accepts `start`.
- R4: `mem_rdata` is sampled one cycle after its read was issued and compared with the word written there in the current pattern. Each inequality adds one to `err_count`.
- R5: `done` is high for exactly one cycle, and `busy` is low in that cycle. `busy` is high from the cycle after start acceptance up to that point. `err_count` holds its final value until the next accepted start.
- R6: `start` has no effect while `busy` is high. A `start` presented in the `done` cycle is accepted.
- R7: An accepted `start` clears `err_count` to zero. The count saturates at 2^CNT_W-1.
- R8: While `inj_en` is high, bit 0 of the data read back from address `inj_addr` is inverted before comparison. This produces one error per pattern on a fault-free store.
- R9: With two-word entries, both words of entry e hold the value e after the final pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; accepted only when `busy` is low |
| inj_en | input | 1 | Enable fault injection on readback |
| inj_addr | input | AW | Address whose readback bit 0 is inverted |
| mem_we | output | 1 | Write strobe to the storage under test |
| mem_re | output | 1 | Read strobe to the storage under test |
| mem_addr | output | AW | Word address for the write or read |
| mem_wdata | output | DATA_W | Pattern word being written |
| mem_rdata | input | DATA_W | Read data, valid one cycle after `mem_re` |
| busy | output | 1 | Run in progress, including the final comparison |
| done | output | 1 | One-cycle pulse at the end of a run |
| err_count | output | CNT_W | Saturating mismatch count of the last run |

## Verification
Two things can meet in a single cycle.

The first is a genuine storage fault and an injected fault on the same comparison. The bench models a stuck bit at one address and also injects on that address. A stuck bit alone yields three errors, because only three of the five patterns hold a zero in that bit position. With injection added, every pattern must count exactly once, giving five, never more.

The second is a new `start` landing in the same cycle as `done`. The bench chains two runs this way and checks that the second run is accepted, that the count was cleared, and that its length is exact. It also checks that a `start` pulsed mid-run leaves the length and the count untouched.

// File: rtl/ptst_pkg.sv
package ptst_pkg;
  typedef enum logic [2:0] {
    PAT_ZERO   = 3'd0,
    PAT_ONES   = 3'd1,
    PAT_ALT_HI = 3'd2,
    PAT_ALT_LO = 3'd3,
    PAT_INDEX  = 3'd4
  } pat_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WRITE = 2'd1,
    SQ_READ  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/ptst_sequencer.sv
module ptst_sequencer
  import ptst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AW     = 5,
  parameter int NADDR  = 32,
  parameter int WSHIFT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              mem_we,
  output logic              mem_re,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              active,
  output logic              rd_last
);
  localparam logic [AW-1:0] LAST = AW'(NADDR - 1);

  sq_state_e         state_q;
  pat_e              pat_q;
  logic [AW-1:0]     addr_q;
  logic [AW-1:0]     entry_idx;
  logic [DATA_W-1:0] pat_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      pat_q   <= PAT_ZERO;
      addr_q  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (go) begin
            state_q <= SQ_WRITE;
            pat_q   <= PAT_ZERO;
            addr_q  <= '0;
          end
        end
        SQ_WRITE: begin
          if (addr_q == LAST) begin
            addr_q  <= '0;
            state_q <= SQ_READ;
          end else begin
            addr_q <= addr_q + AW'(1);
          end
        end
        SQ_READ: begin
          if (addr_q == LAST) begin
            addr_q <= '0;
            if (pat_q == PAT_INDEX) begin
              state_q <= SQ_IDLE;
            end else begin
              state_q <= SQ_WRITE;
              pat_q   <= pat_e'(pat_q + 3'd1);
            end
          end else begin
            addr_q <= addr_q + AW'(1);
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  // entry number: all words of a multi-word entry share it
  assign entry_idx = addr_q >> WSHIFT;

  always_comb begin
    case (pat_q)
      PAT_ZERO:   pat_word = '0;
      PAT_ONES:   pat_word = '1;
      PAT_ALT_HI: pat_word = {(DATA_W/2){2'b10}};
      PAT_ALT_LO: pat_word = {(DATA_W/2){2'b01}};
      default:    pat_word = DATA_W'(entry_idx);
    endcase
  end

  assign mem_we    = (state_q == SQ_WRITE);
  assign mem_re    = (state_q == SQ_READ);
  assign mem_addr  = addr_q;
  assign mem_wdata = pat_word;
  assign active    = (state_q != SQ_IDLE);
  assign rd_last   = mem_re && (pat_q == PAT_INDEX) && (addr_q == LAST);
endmodule

// File: rtl/ptst_compare.sv
module ptst_compare #(
  parameter int DATA_W = 32,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [AW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] rd_exp,
  input  logic              rd_last,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              inj_en,
  input  logic [AW-1:0]     inj_addr,
  output logic              pending,
  output logic              mismatch,
  output logic              finished
);
  logic              vld_q, last_q, done_q;
  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] exp_q;
  logic [DATA_W-1:0] observed;

  // delay line matching the one-cycle read latency of the store
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      exp_q  <= '0;
    end else begin
      vld_q  <= rd_fire;
      last_q <= rd_last;
      done_q <= vld_q && last_q;
      if (rd_fire) begin
        addr_q <= rd_addr;
        exp_q  <= rd_exp;
      end
    end
  end

  assign observed = mem_rdata ^ {{(DATA_W-1){1'b0}}, (inj_en && (addr_q == inj_addr))};
  assign mismatch = vld_q && (observed != exp_q);
  assign pending  = vld_q;
  assign finished = done_q;
endmodule

// File: rtl/ptst_err_counter.sv
module ptst_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (bump && (count != TOP)) begin
      count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pattern_store_tester.sv
module pattern_store_tester #(
  parameter int DATA_W          = 32,
  parameter int ENTRIES         = 32,
  parameter int WORDS_PER_ENTRY = 1,
  parameter int CNT_W           = 16,
  localparam int NADDR          = ENTRIES * WORDS_PER_ENTRY,
  localparam int AW             = $clog2(NADDR),
  localparam int WSHIFT         = $clog2(WORDS_PER_ENTRY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              inj_en,
  input  logic [AW-1:0]     inj_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  err_count
);
  logic seq_active, cmp_pending, cmp_bad, rd_last, start_acc;

  assign busy      = seq_active || cmp_pending;
  assign start_acc = start && !busy;

  ptst_sequencer #(
    .DATA_W(DATA_W), .AW(AW), .NADDR(NADDR), .WSHIFT(WSHIFT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .go(start_acc),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .active(seq_active), .rd_last(rd_last)
  );

  ptst_compare #(.DATA_W(DATA_W), .AW(AW)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .rd_fire(mem_re), .rd_addr(mem_addr), .rd_exp(mem_wdata), .rd_last(rd_last),
    .mem_rdata(mem_rdata), .inj_en(inj_en), .inj_addr(inj_addr),
    .pending(cmp_pending), .mismatch(cmp_bad), .finished(done)
  );

  ptst_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .bump(cmp_bad), .count(err_count)
  );
endmodule

// File: rtl/ptst_checker.sv
module ptst_checker #(
  parameter int AW    = 5,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             mem_we,
  input logic             mem_re,
  input logic [AW-1:0]    mem_addr,
  input logic [CNT_W-1:0] err_count
);
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_wstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  p_rstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_we && !mem_re));

  p_busy_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (err_count == '0));

  p_cnt_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && !busy) |=> (err_count >= $past(err_count)));
endmodule

bind pattern_store_tester ptst_checker #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .err_count(err_count)
);

// File: tb/tb_pattern_store_tester.sv
`timescale 1ns/1ps
module tb_pattern_store_tester;
  localparam int NA = 32;   // single-word config
  localparam int NT = 128;  // 64 entries x 2 words

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  int total = 0, bad = 0;

  // ---------------- single-word instance ----------------
  logic        a_start = 0, a_inj_en = 0;
  logic [4:0]  a_inj_addr = '0;
  logic        a_we, a_re, a_busy, a_done;
  logic [4:0]  a_addr;
  logic [31:0] a_wdata, a_rdata;
  logic [15:0] a_err;
  logic        a_invert = 0, a_stuck_en = 0;
  logic [4:0]  a_stuck_addr = '0;
  logic [31:0] memA [NA];

  pattern_store_tester dut (
    .clk(clk), .rst_n(rst_n), .start(a_start), .inj_en(a_inj_en), .inj_addr(a_inj_addr),
    .mem_we(a_we), .mem_re(a_re), .mem_addr(a_addr), .mem_wdata(a_wdata),
    .mem_rdata(a_rdata), .busy(a_busy), .done(a_done), .err_count(a_err)
  );

  function automatic logic [31:0] a_view(input logic [4:0] ad);
    logic [31:0] v;
    v = memA[ad];
    if (a_invert) v = ~v;
    if (a_stuck_en && ad == a_stuck_addr) v[7] = 1'b1;
    return v;
  endfunction

  always @(posedge clk) begin
    if (a_we) memA[a_addr] <= a_wdata;
    if (a_re) a_rdata <= a_view(a_addr);
  end

  // ---------------- two-word-entry instance ----------------
  logic        t_start = 0, t_inj_en = 0, t_invert = 0;
  logic [6:0]  t_inj_addr = '0;
  logic        t_we, t_re, t_busy, t_done;
  logic [6:0]  t_addr;
  logic [31:0] t_wdata, t_rdata;
  logic [7:0]  t_err;
  logic [31:0] memT [NT];

  pattern_store_tester #(.ENTRIES(64), .WORDS_PER_ENTRY(2), .CNT_W(8)) dut_tbl (
    .clk(clk), .rst_n(rst_n), .start(t_start), .inj_en(t_inj_en), .inj_addr(t_inj_addr),
    .mem_we(t_we), .mem_re(t_re), .mem_addr(t_addr), .mem_wdata(t_wdata),
    .mem_rdata(t_rdata), .busy(t_busy), .done(t_done), .err_count(t_err)
  );

  always @(posedge clk) begin
    if (t_we) memT[t_addr] <= t_wdata;
    if (t_re) t_rdata <= t_invert ? ~memT[t_addr] : memT[t_addr];
  end

  // ---------------- helpers ----------------
  function automatic logic [31:0] patval(input int p, input int idx);
    case (p)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'hAAAA_AAAA;
      3: return 32'h5555_5555;
      default: return 32'(idx);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one run on the single-word instance
  // chained: start already presented in previous done cycle
  // mid: pulse start while busy; chain_next: present start in the done cycle
  task automatic run_a(input int exp_err, input bit chained, input bit mid, input bit chain_next, input string tag);
    int n = 0, seq_bad = 0, busy_bad = 0;
    if (!chained) begin
      @(negedge clk) a_start = 1;
    end
    @(negedge clk) a_start = 0;
    if (chained) chk(a_err == 0 && a_busy, {tag, " R6 R7 start in done cycle accepted, count cleared"}, {15'd0, a_busy, a_err}, 32'h1_0000);
    while (!a_done && n < 5000) begin
      if (n < 10*NA) begin
        int p = n / (2*NA);
        int w = n % (2*NA);
        bit ok;
        if (w < NA) ok = a_we && !a_re && a_addr == 5'(w) && a_wdata == patval(p, w);
        else        ok = a_re && !a_we && a_addr == 5'(w - NA);
        if (!ok) seq_bad++;
      end
      if (!a_busy) busy_bad++;
      if (mid && n == 100) a_start = 1;
      if (mid && n == 101) a_start = 0;
      @(negedge clk);
      n++;
    end
    chk(n == 10*NA + 1, {tag, " R3 run length"}, 32'(n), 32'(10*NA + 1));
    chk(seq_bad == 0, {tag, " R2 R3 pattern/address sequence"}, 32'(seq_bad), 0);
    chk(busy_bad == 0 && !a_busy, {tag, " R5 busy span"}, 32'(busy_bad), 0);
    chk(a_err == 16'(exp_err), {tag, " R4 R8 error count"}, 32'(a_err), 32'(exp_err));
    if (chain_next) begin
      a_start = 1;
    end else begin
      @(negedge clk);
      chk(!a_done && !a_busy, {tag, " R5 R6 single done pulse, no restart"}, {30'd0, a_done, a_busy}, 0);
      chk(a_err == 16'(exp_err), {tag, " R5 count held"}, 32'(a_err), 32'(exp_err));
    end
  endtask

  task automatic run_t(input int exp_err, input string tag);
    int n = 0;
    @(negedge clk) t_start = 1;
    @(negedge clk) t_start = 0;
    while (!t_done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(n == 10*NT + 1, {tag, " R3 run length"}, 32'(n), 32'(10*NT + 1));
    chk(t_err == 8'(exp_err), {tag, " R4 R7 R8 error count"}, 32'(t_err), 32'(exp_err));
  endtask

  bit finished = 0;

  initial begin
    #800000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!a_busy && !a_done && !a_we && !a_re && a_err == 0, "R1 reset state",
        {27'd0, a_busy, a_done, a_we, a_re, 1'b0}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!a_busy && a_err == 0, "R1 idle after reset", {15'd0, a_busy, a_err}, 0);

    run_a(0, 0, 0, 0, "clean");
    begin
      int wrong = 0;
      for (int i = 0; i < NA; i++) if (memA[i] != 32'(i)) wrong++;
      chk(wrong == 0, "R2 index pattern left in store", 32'(wrong), 0);
    end

    a_inj_en = 1; a_inj_addr = 5'd5;
    run_a(5, 0, 0, 0, "inject addr5 R8");
    a_inj_addr = 5'd31;
    run_a(5, 0, 0, 0, "inject last addr R8");
    a_inj_en = 0;

    a_stuck_en = 1; a_stuck_addr = 5'd9;
    run_a(3, 0, 0, 0, "stuck bit R4");
    a_inj_en = 1; a_inj_addr = 5'd9;
    run_a(5, 0, 0, 0, "stuck plus inject same addr R4 R8");
    a_stuck_en = 0;

    a_inj_addr = 5'd0;
    run_a(5, 0, 1, 1, "start mid-run ignored R6");
    a_inj_en = 0;
    run_a(0, 1, 0, 0, "chained clean R6 R7");

    a_invert = 1;
    run_a(10*NA/2, 0, 0, 0, "all corrupt R4");
    a_invert = 0;

    run_t(0, "table clean R9");
    begin
      int wrong = 0;
      for (int i = 0; i < NT; i++) if (memT[i] != 32'(i >> 1)) wrong++;
      chk(wrong == 0, "R9 both words hold entry number", 32'(wrong), 0);
    end
    t_inj_en = 1; t_inj_addr = 7'd127;
    run_t(5, "table inject last word R8");
    t_inj_en = 0;
    t_invert = 1;
    run_t(255, "table saturate R7");
    t_invert = 0;
    run_t(0, "table clear after saturate R7");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule